// File: doc/BRIEF.md
# Partitioned Masked CAM Compare

This block holds a small table of 64-bit words, sixteen by default, each with its own valid bit. On a compare strobe it checks a 64-bit comparand against every valid word in parallel. It registers three results: whether any word matched, whether two or more matched, and the index of the lowest-numbered matching word. Only part of each word needs to take part in the compare. A configuration code picks 64, 48, 32 or 16 compared bits and says whether the rest of the word, which is uncompared storage, lies at the high or the low end. On top of that, one of two loadable mask registers can hide further bit positions from the compare, or no mask can be applied.

Several such blocks can be chained. Each block takes an active-low match flag from its upstream neighbour and drives a combined active-low flag downstream. When the flag enable is off, the block drops out of the chain: the downstream flag simply copies the upstream one, and requests to invalidate the highest-priority matching entry are ignored. The local hit, multiple-match and index outputs always show the true compare result. Entries are written and invalidated through a simple single-cycle port.

Top module: `cam_part_cmp`

## Requirements
- R1: Synchronous active-low reset clears every valid bit and both mask registers, and sets `local_hit` to 0, `multi_n` to 1 and `hit_idx` to 0.
- R2: A cycle with `wr_en` stores `wr_data` at `wr_idx` and marks it valid. A cycle with `inv_en` clears the valid bit at `inv_idx`, and invalidate wins when both name the same entry. An invalid entry never matches.
- R3: `part_cfg` selects the compared bits as 16-bit segments, with segment 0 holding bits 15:0. 0 and 7 compare all 64 bits. 1, 2 and 3 compare the low 48, 32 and 16 bits. 4, 5 and 6 compare the high 48, 32 and 16 bits. Bits outside the compared field never affect a match.
- R4: `msk_cfg` 1 applies mask register 1 and 2 applies mask register 2. 0 and 3 apply no mask. A mask bit of 1 excludes that position from the compare. A cycle with `mk_we` loads `mk_data` into mask register 1 when `mk_sel` is 0, or into mask register 2 when it is 1.
- R5: Compare results appear on the outputs in the cycle after the cycle in which `cmp_strobe` is high. They hold until the next strobe, whatever the comparand does in between.
- R6: `local_hit` is 1 when at least one valid entry matches. `hit_idx` is then the lowest-numbered matching entry.
- R7: `multi_n` is 0 exactly when two or more valid entries match.
- R8: With `mflag_en` at 1, `flag_n` is 0 when `casc_in_n` is 0 or `local_hit` is 1. With `mflag_en` at 0, `flag_n` equals `casc_in_n`.
- R9: `mflag_en` has no effect on `local_hit`, `multi_n` or `hit_idx`.
- R10: A cycle with `hpm_inv` clears the valid bit of entry `hit_idx` when `mflag_en` is 1 and `local_hit` is 1. When `mflag_en` is 0 the request is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write entry strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_data | input | 64 | Word to store |
| inv_en | input | 1 | Invalidate entry strobe |
| inv_idx | input | 4 | Entry index to invalidate |
| mk_we | input | 1 | Mask register load strobe |
| mk_sel | input | 1 | Mask register to load: 0 first, 1 second |
| mk_data | input | 64 | Mask value, 1 excludes a bit |
| part_cfg | input | 3 | Compare field partition code |
| msk_cfg | input | 2 | Mask choice for the compare |
| mflag_en | input | 1 | Cascade match flag enable |
| cmp_strobe | input | 1 | Start a compare |
| comparand | input | 64 | Value to search for |
| hpm_inv | input | 1 | Invalidate the highest-priority matching entry |
| casc_in_n | input | 1 | Upstream match flag, active low |
| flag_n | output | 1 | Downstream match flag, active low |
| multi_n | output | 1 | Two or more matches, active low |
| local_hit | output | 1 | This block has a match |
| hit_idx | output | 4 | Lowest-numbered matching entry |

## Verification
A wrong compared-bit field or a wrong mask choice shows up one cycle after the strobe as a hit, index or multiple-match value that differs from the arithmetic reference. The sweep places single-bit differences in every segment under every partition and mask choice, so each such fault is caught. A stuck valid bit, or a request ignored when it should act, shows up at the next strobe as a changed index or a hit where none should be. Errors in the cascade path are visible on `flag_n` in the same cycle that `casc_in_n` changes.

// File: rtl/cam_pkg.sv
// Package: shared encodings for the partitioned masked CAM compare.
// Assumes the word is a whole number of equal segments.
package cam_pkg;

    typedef enum logic [1:0] {
        MSK_NONE     = 2'd0,
        MSK_FIRST    = 2'd1,
        MSK_SECOND   = 2'd2,
        MSK_NONE_ALT = 2'd3
    } msk_sel_e;

    // Number of compared segments for a partition code.
    function automatic int cam_segs(input logic [2:0] code, input int nseg);
        case (code)
            3'd1, 3'd4: cam_segs = nseg - 1;
            3'd2, 3'd5: cam_segs = nseg - 2;
            3'd3, 3'd6: cam_segs = nseg - 3;
            default:    cam_segs = nseg;
        endcase
    endfunction

    // True when the uncompared storage sits at the high end of the word.
    function automatic logic ram_on_high(input logic [2:0] code);
        ram_on_high = (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction

endpackage

// File: rtl/cam_care_gen.sv
// Module: cam_care_gen
// Builds the per-bit compare enable from the partition code and the
// selected mask. A 1 in care_o means that bit takes part in the compare.
// Assumes WORD_W is a multiple of SEG_W.
module cam_care_gen
    import cam_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int SEG_W  = 16
) (
    input  logic [2:0]        part_cfg,
    input  logic [1:0]        msk_cfg,
    input  logic [WORD_W-1:0] mask_one,
    input  logic [WORD_W-1:0] mask_two,
    output logic [WORD_W-1:0] care_o
);
    localparam int NSEG = WORD_W / SEG_W;

    logic [NSEG-1:0]   seg_on;
    logic [WORD_W-1:0] part_care;

    // Decide which segments belong to the compared field.
    always_comb begin
        int k;
        k = cam_segs(part_cfg, NSEG);
        for (int s = 0; s < NSEG; s++) begin
            if (ram_on_high(part_cfg))
                seg_on[s] = (s < k);
            else
                seg_on[s] = (s >= NSEG - k);
        end
    end

    // Spread each segment flag across its bits.
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign part_care[g*SEG_W +: SEG_W] = {SEG_W{seg_on[g]}};
    end

    // Remove masked positions according to the mask choice.
    always_comb begin
        case (msk_sel_e'(msk_cfg))
            MSK_FIRST:  care_o = part_care & ~mask_one;
            MSK_SECOND: care_o = part_care & ~mask_two;
            default:    care_o = part_care;
        endcase
    end
endmodule

// File: rtl/cam_store.sv
// Module: cam_store
// Holds the entry words and their valid bits. Writes set valid; an
// invalidate or a highest-priority clear in the same cycle wins.
// Assumes at most one write per cycle.
module cam_store #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              hpm_clr,
    input  logic [IDX_W-1:0]  hpm_idx,
    output logic [WORD_W-1:0] mem_o [ENTRIES],
    output logic [ENTRIES-1:0] valid_o
);
    logic [WORD_W-1:0]  mem_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // Store write data; contents need no reset because valid gates them.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= wr_data;
    end

    // Maintain valid bits; later assignments take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (wr_en)   valid_q[wr_idx]  <= 1'b1;
            if (inv_en)  valid_q[inv_idx] <= 1'b0;
            if (hpm_clr) valid_q[hpm_idx] <= 1'b0;
        end
    end

    assign mem_o   = mem_q;
    assign valid_o = valid_q;

    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !valid_q[$past(inv_idx)]); // R2
endmodule

// File: rtl/cam_match_vec.sv
// Module: cam_match_vec
// Compares the comparand with every entry under the care vector.
// Assumes care_o style input: 1 marks a compared bit.
module cam_match_vec #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 64
) (
    input  logic [WORD_W-1:0]  mem_i [ENTRIES],
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [WORD_W-1:0]  comparand,
    input  logic [WORD_W-1:0]  care,
    output logic [ENTRIES-1:0] mvec
);
    // One comparator per entry; an invalid entry never matches.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        assign mvec[e] = valid_i[e] && (((mem_i[e] ^ comparand) & care) == '0);
    end
endmodule

// File: rtl/cam_prio.sv
// Module: cam_prio
// Registers hit, multiple-hit and lowest matching index on a strobe and
// holds them otherwise. Lowest index has the highest priority.
module cam_prio #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  logic [ENTRIES-1:0] mvec,
    output logic               hit_o,
    output logic               multi_n_o,
    output logic [IDX_W-1:0]   idx_o
);
    localparam logic [ENTRIES-1:0] ONE_V = ENTRIES'(1);

    logic [IDX_W-1:0] idx_d;
    logic             multi_d;

    // Find the lowest-numbered set bit.
    always_comb begin
        idx_d = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (mvec[i]) idx_d = IDX_W'(i);
        end
    end

    // Two or more set bits leave something after clearing the lowest.
    assign multi_d = ((mvec & (mvec - ONE_V)) != '0);

    // Capture results on the strobe, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o     <= 1'b0;
            multi_n_o <= 1'b1;
            idx_o     <= '0;
        end else if (strobe) begin
            hit_o     <= (mvec != '0);
            multi_n_o <= !multi_d;
            idx_o     <= idx_d;
        end
    end

    AST_HIT_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (!hit_o || (((($past(mvec) >> idx_o) & ONE_V) == ONE_V) &&
                               (($past(mvec) & ((ONE_V << idx_o) - ONE_V)) == '0)))); // R6
    AST_MULTI_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !multi_n_o |-> hit_o); // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(hit_o) && $stable(multi_n_o) && $stable(idx_o))); // R5
endmodule

// File: rtl/cam_part_cmp.sv
// Module: cam_part_cmp (top)
// Partitioned, maskable CAM compare with cascade match flag. Holds the
// two mask registers and the flag logic; entries, care vector, compare
// and priority live in submodules. Assumes single-cycle port operations.
module cam_part_cmp
    import cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 64,
    parameter int SEG_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              mk_we,
    input  logic              mk_sel,
    input  logic [WORD_W-1:0] mk_data,
    input  logic [2:0]        part_cfg,
    input  logic [1:0]        msk_cfg,
    input  logic              mflag_en,
    input  logic              cmp_strobe,
    input  logic [WORD_W-1:0] comparand,
    input  logic              hpm_inv,
    input  logic              casc_in_n,
    output logic              flag_n,
    output logic              multi_n,
    output logic              local_hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [WORD_W-1:0]  mask_one_q, mask_two_q, care;
    logic [WORD_W-1:0]  mem_w [ENTRIES];
    logic [ENTRIES-1:0] valid_w, mvec;
    logic               hpm_clr;

    // Load the two mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_one_q <= '0;
            mask_two_q <= '0;
        end else if (mk_we) begin
            if (mk_sel) mask_two_q <= mk_data;
            else        mask_one_q <= mk_data;
        end
    end

    // Highest-priority clear acts only with the flag enabled and a hit.
    assign hpm_clr = hpm_inv && mflag_en && local_hit;

    cam_store #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .inv_en(inv_en), .inv_idx(inv_idx),
        .hpm_clr(hpm_clr), .hpm_idx(hit_idx),
        .mem_o(mem_w), .valid_o(valid_w)
    );

    cam_care_gen #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_care (
        .part_cfg(part_cfg), .msk_cfg(msk_cfg),
        .mask_one(mask_one_q), .mask_two(mask_two_q), .care_o(care)
    );

    cam_match_vec #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_match (
        .mem_i(mem_w), .valid_i(valid_w), .comparand(comparand),
        .care(care), .mvec(mvec)
    );

    cam_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .strobe(cmp_strobe), .mvec(mvec),
        .hit_o(local_hit), .multi_n_o(multi_n), .idx_o(hit_idx)
    );

    // Cascade flag: merge local hit when enabled, else pass upstream flag.
    assign flag_n = mflag_en ? (casc_in_n && !local_hit) : casc_in_n;

    AST_HPM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hpm_inv && !mflag_en && !wr_en && !inv_en) |=> $stable(valid_w)); // R10
    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mflag_en && local_hit) |-> !flag_n); // R8
endmodule

// File: tb/cam_part_cmp_tb.sv
module cam_part_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, inv_en = 1'b0, mk_we = 1'b0, mk_sel = 1'b0;
    logic [3:0]  wr_idx = '0, inv_idx = '0;
    logic [63:0] wr_data = '0, mk_data = '0, comparand = '0;
    logic [2:0]  part_cfg = '0;
    logic [1:0]  msk_cfg = '0;
    logic        mflag_en = 1'b1, cmp_strobe = 1'b0, hpm_inv = 1'b0, casc_in_n = 1'b1;
    logic        flag_n, multi_n, local_hit;
    logic [3:0]  hit_idx;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [63:0] ref_mem [16];
    logic        ref_val [16];
    logic [63:0] ref_m1 = '0, ref_m2 = '0;
    logic        e_hit, e_multi;
    logic [3:0]  e_idx;

    always #5 clk = ~clk;

    cam_part_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .inv_en(inv_en), .inv_idx(inv_idx), .mk_we(mk_we), .mk_sel(mk_sel),
        .mk_data(mk_data), .part_cfg(part_cfg), .msk_cfg(msk_cfg), .mflag_en(mflag_en),
        .cmp_strobe(cmp_strobe), .comparand(comparand), .hpm_inv(hpm_inv),
        .casc_in_n(casc_in_n), .flag_n(flag_n), .multi_n(multi_n),
        .local_hit(local_hit), .hit_idx(hit_idx)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compared-bit vector from the partition code and mask choice (R3, R4).
    function automatic logic [63:0] ref_care(input int code, input int ms);
        logic [63:0] c = '0;
        int k = (code == 0 || code == 7) ? 4 : (code <= 3 ? 4 - code : 7 - code);
        for (int s = 0; s < 4; s++) begin
            logic on = (code >= 1 && code <= 3) ? (s < k) : (s >= 4 - k);
            if (on) c[s*16 +: 16] = 16'hFFFF;
        end
        if (ms == 1) c = c & ~ref_m1;
        if (ms == 2) c = c & ~ref_m2;
        return c;
    endfunction

    task automatic ref_eval(input logic [63:0] cv);
        logic [63:0] care = ref_care(int'(part_cfg), int'(msk_cfg));
        int cnt = 0;
        e_hit = 1'b0; e_idx = '0;
        for (int i = 0; i < 16; i++) begin
            if (ref_val[i] && (((ref_mem[i] ^ cv) & care) == 64'd0)) begin
                if (!e_hit) e_idx = 4'(i);
                e_hit = 1'b1;
                cnt++;
            end
        end
        e_multi = (cnt >= 2);
    endtask

    task automatic wr(input int idx, input logic [63:0] d);
        @(negedge clk); wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        ref_mem[idx] = d; ref_val[idx] = 1'b1;
    endtask

    task automatic inv(input int idx);
        @(negedge clk); inv_en = 1'b1; inv_idx = 4'(idx);
        @(negedge clk); inv_en = 1'b0;
        ref_val[idx] = 1'b0;
    endtask

    task automatic ld_mask(input logic sel, input logic [63:0] d);
        @(negedge clk); mk_we = 1'b1; mk_sel = sel; mk_data = d;
        @(negedge clk); mk_we = 1'b0;
        if (sel) ref_m2 = d; else ref_m1 = d;
    endtask

    task automatic do_cmp(input logic [63:0] cv);
        @(negedge clk); comparand = cv; cmp_strobe = 1'b1;
        @(negedge clk); cmp_strobe = 1'b0;
        #1;
    endtask

    task automatic hpm_pulse();
        @(negedge clk); hpm_inv = 1'b1;
        @(negedge clk); hpm_inv = 1'b0;
        if (mflag_en && e_hit) ref_val[e_idx] = 1'b0;
    endtask

    // Compare and check all outputs against the reference.
    task automatic cmp_chk(input string tag, input logic [63:0] cv);
        ref_eval(cv);
        do_cmp(cv);
        chk({tag, " R6 local_hit"}, 64'(local_hit), 64'(e_hit));
        if (e_hit) chk({tag, " R6 hit_idx"}, 64'(hit_idx), 64'(e_idx));
        chk({tag, " R7 multi_n"}, 64'(multi_n), 64'(!e_multi));
        casc_in_n = 1'b0; #1;
        chk({tag, " R8 flag_n casc0"}, 64'(flag_n), 64'(mflag_en ? 1'b0 : 1'b0));
        casc_in_n = 1'b1; #1;
        chk({tag, " R8 flag_n casc1"}, 64'(flag_n), 64'(mflag_en ? !e_hit : 1'b1));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin ref_mem[i] = '0; ref_val[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 local_hit", 64'(local_hit), 64'd0);
        chk("R1 multi_n", 64'(multi_n), 64'd1);
        chk("R1 hit_idx", 64'(hit_idx), 64'd0);
        chk("R1 flag_n", 64'(flag_n), 64'd1);
        // R1/R2: nothing valid, so no compare can hit
        cmp_chk("R1 R2 empty", 64'd0);

        // R3 R4 sweep over every partition code and mask choice
        ld_mask(1'b0, {$urandom, $urandom});
        ld_mask(1'b1, {$urandom, $urandom});
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 4; m++) begin
                logic [63:0] base = {$urandom, $urandom};
                @(negedge clk); part_cfg = 3'(p); msk_cfg = 2'(m);
                for (int i = 0; i < 16; i++) begin
                    if (i % 4 == 0) wr(i, base);
                    else wr(i, base ^ (64'd1 << ((i * 7 + p * 5 + m * 3) % 64)));
                end
                if ((p + m) % 2 == 0) inv(0);
                cmp_chk("R3 R4 base", base);
                cmp_chk("R3 R4 ent5", ref_mem[5]);
                cmp_chk("R3 R4 ent10", ref_mem[10]);
                cmp_chk("R3 R4 rand", {$urandom, $urandom});
            end
        end

        // Directed set: part 0, no mask, entries 2 and 9 equal
        @(negedge clk); part_cfg = 3'd0; msk_cfg = 2'd0;
        for (int i = 0; i < 16; i++) wr(i, 64'h1000 + 64'(i));
        wr(2, 64'hABCD);
        wr(9, 64'hABCD);
        cmp_chk("R6 R7 pair", 64'hABCD);

        // R5 outputs hold while the comparand changes without a strobe
        @(negedge clk); comparand = 64'h5555; repeat (3) @(negedge clk); #1;
        chk("R5 hold hit", 64'(local_hit), 64'd1);
        chk("R5 hold idx", 64'(hit_idx), 64'd2);
        chk("R5 hold multi", 64'(multi_n), 64'd0);

        // R9 and R8 with the flag disabled
        @(negedge clk); mflag_en = 1'b0;
        cmp_chk("R9 disabled", 64'hABCD);
        chk("R9 idx", 64'(hit_idx), 64'd2);
        chk("R9 multi", 64'(multi_n), 64'd0);

        // R10 ignored when disabled
        hpm_pulse();
        cmp_chk("R10 ignored", 64'hABCD);
        chk("R10 ignored idx", 64'(hit_idx), 64'd2);

        // R10 acts when enabled
        @(negedge clk); mflag_en = 1'b1;
        hpm_pulse();
        cmp_chk("R10 cleared", 64'hABCD);
        chk("R10 next idx", 64'(hit_idx), 64'd9);
        chk("R10 single", 64'(multi_n), 64'd1);

        // R2 invalidate then rewrite
        inv(9);
        cmp_chk("R2 invalid", 64'hABCD);
        chk("R2 no hit", 64'(local_hit), 64'd0);
        wr(9, 64'hABCD);
        cmp_chk("R2 rewritten", 64'hABCD);
        chk("R2 hit back", 64'(hit_idx), 64'd9);

        // R2 write and invalidate of one entry in the same cycle
        @(negedge clk); wr_en = 1'b1; wr_idx = 4'd4; wr_data = 64'h7777;
        inv_en = 1'b1; inv_idx = 4'd4;
        @(negedge clk); wr_en = 1'b0; inv_en = 1'b0;
        ref_mem[4] = 64'h7777; ref_val[4] = 1'b0;
        cmp_chk("R2 inv wins", 64'h7777);
        chk("R2 inv wins hit", 64'(local_hit), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule